// File: doc/BRIEF.md
# ROM Configuration and Emulation Bus Controller

This block owns the configuration word of an on-chip read-only memory and decides how that memory responds to bus cycles. When the chip comes out of reset it captures two of its mode bits from the data bus. The stop bit and the emulation bit are taken from bus lines 14, 13 and 10 while reset is held. The remaining reset values are fixed by parameters. Software then reprograms the address-space selector, the wait-state count and a base address through three register slots. Each write passes through protection rules driven by a lock bit and the stop bit.

For every bus cycle, the block looks for a falling edge on the active-low address strobe. It then tests the address against a naturally aligned window of 2^WIN_BITS bytes at the programmed base, and the cycle's address space against the selector. In normal operation a valid cycle is acknowledged after the programmed number of wait states. In emulation operation the block never acknowledges. It raises a module chip-select instead, so that an outside device can serve the cycle while the system runs an external bus cycle.

Top module: `romcfg_emu_ctrl`

## Requirements
- R1: While rstN is low, the stop bit loads the inverse of wrData[14], and the emulation bit loads 1 only when wrData[13] and wrData[10] are both 0.
- R2: Configuration word (regSel=0) layout: bit 15 stop, bit 13 boot, bit 12 lock, bit 11 emulation, bits 10:9 address-space selector, bits 8:7 wait count. Bits 14 and 6:0 always read 0. Reset loads boot, lock, selector, wait and base from parameters. The stop, boot, lock and emulation bits accept every write.
- R3: While lock (before the write) is 1, writes to the selector, the wait count, base-high (regSel=1, base bits above 15) and base-low (regSel=2, base bits 15:0) are ignored.
- R4: While stop (before the write) is 0, writes to the selector and both base slots are ignored. The wait count remains writable when unlocked.
- R5: A cycle is valid only when its address lies in the window [base aligned down to 2^WIN_BITS, +2^WIN_BITS−1] and busSpace equals the selector. An invalid cycle gets neither busAck nor modCs.
- R6: In normal operation (stop=0, boot=0), a valid read or write sees busAck rise W+1 clock edges after the edge that samples the strobe low, where W is the wait count. It holds until the strobe is released.
- R7: With boot=1 and stop=0, no cycle is acknowledged. With stop=1, boot has no effect.
- R8: In emulation operation (stop=1, emulation=1), modCs rises on the edge that samples the strobe fall for a valid read, and busAck never asserts.
- R9: In emulation operation, a valid write raises modCs only when bdmActive is 1.
- R10: With stop=1 and emulation=0, neither busAck nor modCs asserts.
- R11: On the first edge that samples busAsN high, busAck and modCs drop to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; the data bus is sampled while it is low |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register slot: 0 configuration, 1 base high, 2 base low |
| wrData | input | 16 | Write data; it also carries the reset-sampled data lines |
| rdData | output | 16 | Read data of the selected slot |
| busAsN | input | 1 | Active-low address strobe |
| busAddr | input | ADDR_W | Cycle address |
| busSpace | input | 2 | Cycle address space |
| busWrite | input | 1 | 1 for a write cycle |
| bdmActive | input | 1 | Background debug mode active |
| busAck | output | 1 | Internal acknowledge |
| modCs | output | 1 | Module chip-select for the emulation device |

## Verification
The bench builds the block with a 4 KB window (WIN_BITS=12), base 0x0A0000, and boot and lock both reset to 1. It also resets the selector to 2 and the wait count to 3. With boot at 1, the boot lockout can be seen straight out of reset. With lock at 1, the protection of every field can be tested before software has touched anything. The small window makes both window edges reachable with plain addresses. Each reset pattern on the data bus lands on a distinct stop/emulation combination.

// File: rtl/romcfg_pkg.sv
package romcfg_pkg;

  localparam int BIT_STOP = 15;
  localparam int BIT_BOOT = 13;
  localparam int BIT_LOCK = 12;
  localparam int BIT_EMUL = 11;
  localparam int SPC_LSB  = 9;
  localparam int WT_LSB   = 7;

  localparam int PIN_STOP  = 14;
  localparam int PIN_EMUL0 = 13;
  localparam int PIN_EMUL1 = 10;

  typedef enum logic [1:0] {
    SEL_CFG    = 2'd0,
    SEL_BASEHI = 2'd1,
    SEL_BASELO = 2'd2
  } regSel_e;

  // strobes from control to datapath, already filtered by protection rules
  typedef struct packed {
    logic wrModeBits;
    logic wrSpace;
    logic wrWait;
    logic wrBaseHi;
    logic wrBaseLo;
  } cfgStrobe_t;

  // state from datapath to control
  typedef struct packed {
    logic       stop;
    logic       boot;
    logic       lock;
    logic       emul;
    logic [1:0] space;
    logic [1:0] waitCnt;
    logic       hit;
  } cfgStatus_t;

endpackage

// File: rtl/romcfg_datapath.sv
module romcfg_datapath
  import romcfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned WIN_BITS = 16,
  parameter logic [ADDR_W-1:0] BASE_RST = '0,
  parameter logic BOOT_RST = 1'b0,
  parameter logic LOCK_RST = 1'b0,
  parameter logic [1:0] ASPC_RST = 2'b00,
  parameter logic [1:0] WAIT_RST = 2'b00
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [1:0]        regSel,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  input  logic [ADDR_W-1:0] busAddr,
  output cfgStatus_t        status
);

  localparam int unsigned HI_W = ADDR_W - 16;

  logic              stopQ, bootQ, lockQ, emulQ;
  logic [1:0]        spaceQ, waitQ;
  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] baseAligned;
  logic [ADDR_W-1:0] offset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopQ  <= ~wrData[PIN_STOP];
      emulQ  <= ~wrData[PIN_EMUL0] & ~wrData[PIN_EMUL1];
      bootQ  <= BOOT_RST;
      lockQ  <= LOCK_RST;
      spaceQ <= ASPC_RST;
      waitQ  <= WAIT_RST;
      baseQ  <= BASE_RST;
    end else begin
      if (strobe.wrModeBits) begin
        stopQ <= wrData[BIT_STOP];
        bootQ <= wrData[BIT_BOOT];
        lockQ <= wrData[BIT_LOCK];
        emulQ <= wrData[BIT_EMUL];
      end
      if (strobe.wrSpace) spaceQ <= wrData[SPC_LSB +: 2];
      if (strobe.wrWait)  waitQ  <= wrData[WT_LSB +: 2];
      if (strobe.wrBaseHi) baseQ[ADDR_W-1:16] <= wrData[HI_W-1:0];
      if (strobe.wrBaseLo) baseQ[15:0] <= wrData;
    end
  end

  // window compare: offset from aligned base must fit below 2^WIN_BITS
  assign baseAligned = {baseQ[ADDR_W-1:WIN_BITS], {WIN_BITS{1'b0}}};
  assign offset      = busAddr - baseAligned;

  always_comb begin
    status.stop    = stopQ;
    status.boot    = bootQ;
    status.lock    = lockQ;
    status.emul    = emulQ;
    status.space   = spaceQ;
    status.waitCnt = waitQ;
    status.hit     = ((offset >> WIN_BITS) == '0);
  end

  always_comb begin
    unique case (regSel)
      SEL_CFG:    rdData = {stopQ, 1'b0, bootQ, lockQ, emulQ, spaceQ, waitQ, 7'b0};
      SEL_BASEHI: rdData = 16'(baseQ[ADDR_W-1:16]);
      SEL_BASELO: rdData = baseQ[15:0];
      default:    rdData = '0;
    endcase
  end

  // R3: lock held across an edge keeps protected fields unchanged
  assert_locked_fields_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(lockQ)) |-> ($stable(waitQ) && $stable(spaceQ) && $stable(baseQ)));

  // R4: stop clear keeps selector and base unchanged
  assert_stopped_fields_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(stopQ)) |-> ($stable(spaceQ) && $stable(baseQ)));

endmodule

// File: rtl/romcfg_ctrl.sv
module romcfg_ctrl
  import romcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [1:0] regSel,
  input  cfgStatus_t status,
  output cfgStrobe_t strobe,
  input  logic       busAsN,
  input  logic [1:0] busSpace,
  input  logic       busWrite,
  input  logic       bdmActive,
  output logic       busAck,
  output logic       modCs
);

  logic       asNPrev;
  logic       pending;
  logic [1:0] waitLeft;
  logic       ackQ, csQ;
  logic       strobeFall, cycleValid, emulMode, normalMode, csWanted;

  // write protection uses the lock and stop values before the write
  always_comb begin
    strobe.wrModeBits = regWrEn && (regSel == SEL_CFG);
    strobe.wrWait     = regWrEn && (regSel == SEL_CFG) && !status.lock;
    strobe.wrSpace    = regWrEn && (regSel == SEL_CFG) && !status.lock && status.stop;
    strobe.wrBaseHi   = regWrEn && (regSel == SEL_BASEHI) && !status.lock && status.stop;
    strobe.wrBaseLo   = regWrEn && (regSel == SEL_BASELO) && !status.lock && status.stop;
  end

  assign strobeFall = asNPrev && !busAsN;
  assign cycleValid = status.hit && (busSpace == status.space);
  assign emulMode   = status.stop && status.emul;
  assign normalMode = !status.stop && !status.boot;
  assign csWanted   = cycleValid && emulMode && (!busWrite || bdmActive);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      asNPrev  <= 1'b1;
      pending  <= 1'b0;
      waitLeft <= '0;
      ackQ     <= 1'b0;
      csQ      <= 1'b0;
    end else begin
      asNPrev <= busAsN;
      if (busAsN) begin
        pending <= 1'b0;
        ackQ    <= 1'b0;
        csQ     <= 1'b0;
      end else if (strobeFall) begin
        if (csWanted) csQ <= 1'b1;
        if (cycleValid && normalMode) begin
          pending  <= 1'b1;
          waitLeft <= status.waitCnt;
        end
      end else if (pending) begin
        if (waitLeft == '0) begin
          ackQ    <= 1'b1;
          pending <= 1'b0;
        end else begin
          waitLeft <= waitLeft - 2'd1;
        end
      end
    end
  end

  assign busAck = ackQ;
  assign modCs  = csQ;

  // R8: chip-select and acknowledge never coexist
  assert_cs_excludes_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    modCs |-> !busAck);

  // R11: released strobe clears both outputs on the next edge
  assert_release_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    busAsN |=> (!busAck && !modCs));

  // R6: acknowledge only rises while the strobe has been low for two samples
  assert_ack_inside_cycle_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busAck) |-> ($past(!busAsN) && !busAsN));

endmodule

// File: rtl/romcfg_emu_ctrl.sv
module romcfg_emu_ctrl
  import romcfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned WIN_BITS = 16,
  parameter logic [ADDR_W-1:0] BASE_RST = '0,
  parameter logic BOOT_RST = 1'b0,
  parameter logic LOCK_RST = 1'b0,
  parameter logic [1:0] ASPC_RST = 2'b00,
  parameter logic [1:0] WAIT_RST = 2'b00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  input  logic              busAsN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSpace,
  input  logic              busWrite,
  input  logic              bdmActive,
  output logic              busAck,
  output logic              modCs
);

  cfgStrobe_t strobe;
  cfgStatus_t status;

  romcfg_datapath #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BASE_RST(BASE_RST),
    .BOOT_RST(BOOT_RST), .LOCK_RST(LOCK_RST),
    .ASPC_RST(ASPC_RST), .WAIT_RST(WAIT_RST)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regSel(regSel),
    .wrData(wrData), .rdData(rdData), .busAddr(busAddr), .status(status)
  );

  romcfg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .status(status), .strobe(strobe), .busAsN(busAsN), .busSpace(busSpace),
    .busWrite(busWrite), .bdmActive(bdmActive), .busAck(busAck), .modCs(modCs)
  );

endmodule

// File: tb/romcfg_emu_ctrl_test.sv
`timescale 1ns/1ps
module romcfg_emu_ctrl_test;

  localparam int AW = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [15:0] wrData = 16'h0000;
  logic [15:0] rdData;
  logic busAsN = 1'b1;
  logic [AW-1:0] busAddr = '0;
  logic [1:0] busSpace = 2'd0;
  logic busWrite = 1'b0;
  logic bdmActive = 1'b0;
  logic busAck, modCs;

  int nCompared = 0;
  int nMismatched = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  romcfg_emu_ctrl #(
    .ADDR_W(AW), .WIN_BITS(12), .BASE_RST(24'h0A0000),
    .BOOT_RST(1'b1), .LOCK_RST(1'b1), .ASPC_RST(2'b10), .WAIT_RST(2'd3)
  ) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .wrData(wrData), .rdData(rdData), .busAsN(busAsN), .busAddr(busAddr),
    .busSpace(busSpace), .busWrite(busWrite), .bdmActive(bdmActive),
    .busAck(busAck), .modCs(modCs)
  );

  typedef struct packed {
    logic [15:0] cfg;
    logic [23:0] addr;
    logic [1:0]  space;
    logic        wr;
    logic        bdm;
    logic [3:0]  lat;   // negedges until ack, 0 = none
    logic        cs;
  } vec_t;

  // base 0x0A3000, window 0x0A3000..0x0A3FFF
  localparam vec_t VECS [14] = '{
    '{16'h0200, 24'h0A3004, 2'd1, 1'b0, 1'b0, 4'd2, 1'b0},  // R6 wait 0
    '{16'h0380, 24'h0A3004, 2'd1, 1'b0, 1'b0, 4'd5, 1'b0},  // R6 wait 3
    '{16'h0280, 24'h0A3800, 2'd1, 1'b1, 1'b0, 4'd3, 1'b0},  // R6 write, wait 1
    '{16'h0300, 24'h0A4000, 2'd1, 1'b0, 1'b0, 4'd0, 1'b0},  // R5 above window
    '{16'h0200, 24'h0A3004, 2'd2, 1'b0, 1'b0, 4'd0, 1'b0},  // R5 space mismatch
    '{16'h0100, 24'h0A3FFF, 2'd0, 1'b0, 1'b0, 4'd4, 1'b0},  // R5 top byte, wait 2
    '{16'h0100, 24'h0A2FFF, 2'd0, 1'b0, 1'b0, 4'd0, 1'b0},  // R5 below window
    '{16'h8A00, 24'h0A3000, 2'd1, 1'b0, 1'b0, 4'd0, 1'b1},  // R8 emulation read
    '{16'h8A00, 24'h0A3010, 2'd1, 1'b1, 1'b0, 4'd0, 1'b0},  // R9 write no debug
    '{16'h8A00, 24'h0A3010, 2'd1, 1'b1, 1'b1, 4'd0, 1'b1},  // R9 write in debug
    '{16'h8A00, 24'h0B3000, 2'd1, 1'b0, 1'b0, 4'd0, 1'b0},  // R5 R8 outside
    '{16'h8200, 24'h0A3000, 2'd1, 1'b0, 1'b0, 4'd0, 1'b0},  // R10 array disabled
    '{16'h2200, 24'h0A3000, 2'd1, 1'b0, 1'b0, 4'd0, 1'b0},  // R7 boot blocks
    '{16'hAA00, 24'h0A3000, 2'd1, 1'b0, 1'b0, 4'd0, 1'b1}   // R7 stop overrides boot
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [15:0] pins);
    @(negedge clk);
    rstN = 1'b0;
    wrData = pins;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    wrData = 16'h0000;
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    regWrEn = 1'b1;
    regSel = sel;
    wrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
    wrData = 16'h0000;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [15:0] data);
    @(negedge clk);
    regSel = sel;
    #1 data = rdData;
  endtask

  task automatic runAccess(input logic [23:0] addr, input logic [1:0] spc,
                           input logic wr, input logic bdm,
                           output int lat, output logic csSeen);
    @(negedge clk);
    busAddr = addr;
    busSpace = spc;
    busWrite = wr;
    bdmActive = bdm;
    busAsN = 1'b0;
    lat = 0;
    csSeen = 1'b0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (i == 1) csSeen = modCs;
      if (busAck && lat == 0) lat = i;
    end
    busAsN = 1'b1;
    @(negedge clk);
    check("R11 release", {30'd0, busAck, modCs}, 32'd0);
    bdmActive = 1'b0;
    busWrite = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nCompared++;
      nMismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] rd;
    int lat;
    logic cs;

    // R1 R2 reset patterns
    doReset(16'h0000);
    check("R1 outputs idle", {30'd0, busAck, modCs}, 32'd0);
    readReg(2'd0, rd); check("R1 R2 pins low", rd, 16'hBD80);
    readReg(2'd1, rd); check("R2 base high", rd, 16'h000A);
    readReg(2'd2, rd); check("R2 base low", rd, 16'h0000);
    doReset(16'h4400);
    readReg(2'd0, rd); check("R1 pins 14,10 high", rd, 16'h3580);
    // R7 boot lockout right after reset
    runAccess(24'h0A0100, 2'd2, 1'b0, 1'b0, lat, cs);
    check("R7 boot after reset", {31'd0, lat != 0 || cs}, 32'd0);
    doReset(16'h2000);
    readReg(2'd0, rd); check("R1 pin 13 high only", rd, 16'hB580);

    // R3 lock protection (stop=1, lock=1)
    doReset(16'h0000);
    writeReg(2'd0, 16'hBA00);
    readReg(2'd0, rd); check("R3 locked fields", rd, 16'hBD80);
    writeReg(2'd2, 16'h1234);
    readReg(2'd2, rd); check("R3 locked base low", rd, 16'h0000);
    writeReg(2'd1, 16'h0055);
    readReg(2'd1, rd); check("R3 locked base high", rd, 16'h000A);
    writeReg(2'd0, 16'hAA00);
    readReg(2'd0, rd); check("R3 unlock write keeps fields", rd, 16'hAD80);

    // R4 stop protection
    writeReg(2'd0, 16'h0280);
    readReg(2'd0, rd); check("R4 fields set while stopped", rd, 16'h0280);
    writeReg(2'd0, 16'h0700);
    readReg(2'd0, rd); check("R4 selector held, wait written", rd, 16'h0300);
    writeReg(2'd2, 16'h5000);
    readReg(2'd2, rd); check("R4 base low held", rd, 16'h0000);

    // R2 reserved bits
    writeReg(2'd0, 16'h8000);
    writeReg(2'd0, 16'hFFFF);
    readReg(2'd0, rd); check("R2 reserved bits read 0", rd, 16'hBF80);

    // vector table
    for (int v = 0; v < 14; v++) begin
      writeReg(2'd0, 16'h8000);
      writeReg(2'd1, 16'h000A);
      writeReg(2'd2, 16'h3000);
      writeReg(2'd0, VECS[v].cfg);
      runAccess(VECS[v].addr, VECS[v].space, VECS[v].wr, VECS[v].bdm, lat, cs);
      check($sformatf("R5-R10 vector %0d latency", v), lat, 32'(VECS[v].lat));
      check($sformatf("R8 R9 vector %0d chip-select", v), {31'd0, cs}, {31'd0, VECS[v].cs});
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

endmodule